// File: doc/BRIEF.md
# Binary Exponential Backoff Controller

This block decides when a station may transmit on a shared medium that has carrier sensing and collision detection. When a send request arrives, it waits until the line has been quiet for a set number of clock cycles. It then raises transmit-enable. If the collision input fires while transmit-enable is high, the block drops transmit-enable at once and pulses abort. It then waits a random whole number of slot times before it competes for the line again.

The random wait comes from a free-running LFSR. Its low bits are masked to a range that doubles with each successive collision, up to a cap. A completed transmission produces a one-cycle success pulse. When the collision count reaches the attempt limit, the block produces a one-cycle failure pulse and returns to idle. The frame transmitter and the collision sensing circuit sit outside this block. They connect through the done and collision flags.

Top module: `backoff_ctrl`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it is released, transmit-enable, abort, success and failure are low and the attempt count is 0.
- R2: A send request sampled in idle starts deferral. If the carrier input was already low at the preceding QUIET_CYC clock edges, transmit-enable is high on the second clock edge after the request.
- R3: Any clock edge at which the carrier input is high restarts the quiet count. Transmit-enable rises on the (QUIET_CYC+1)-th clock edge, counting the first edge at which the carrier input is low.
- R4: A collision sampled while transmit-enable is high clears transmit-enable on that edge. The same edge raises abort for exactly one cycle and increments the attempt count.
- R5: After the n-th collision (n below MAX_ATTEMPTS), with the line quiet, transmit-enable rises again k*SLOT_CYC+2 cycles after the abort cycle. Here k is an integer from 0 to 2^min(n,BACKOFF_CAP)-1, so the range doubles with each collision until it reaches the cap.
- R6: The done flag sampled while transmitting, with no collision, clears transmit-enable. It also produces a one-cycle success pulse and returns the attempt count to 0.
- R7: When collision and done are sampled on the same edge, the collision wins: abort is pulsed and success stays low.
- R8: The MAX_ATTEMPTS-th collision pulses failure together with abort for one cycle and leaves the attempt count at MAX_ATTEMPTS. The block then returns to idle, and transmit-enable stays low until a new request.
- R9: A new request accepted in idle clears the attempt count on the edge that samples it.
- R10: A send request sampled while the block is not idle has no effect. After the current transmission ends, transmit-enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_req_i | input | 1 | Request to send one frame |
| carrier_i | input | 1 | Line is busy |
| collision_i | input | 1 | Collision detected on the line |
| tx_done_i | input | 1 | Frame transmission completed |
| tx_en_o | output | 1 | Transmitter may drive the line |
| abort_o | output | 1 | One-cycle pulse: stop the current frame |
| success_o | output | 1 | One-cycle pulse: frame delivered |
| fail_o | output | 1 | One-cycle pulse: attempt limit reached |
| attempts_o | output | $clog2(MAX_ATTEMPTS+1) | Collisions counted for the current frame |

## Verification
Abort, success and failure are registered and appear on the edge that samples collision or done. The bench therefore checks them at the falling edge that follows the one cycle in which it drove the flag. Transmit-enable rises two edges after a request when the line is already quiet, and QUIET_CYC+1 edges after the carrier drops when it is not. The bench counts falling edges from its own stimulus and compares against those exact numbers. After a collision, it counts cycles from the abort sample until transmit-enable rises. That gap must be 2 plus a multiple of SLOT_CYC, with the multiple inside the range for that collision number. The bench applies this bound on every attempt of several full runs to the failure limit.

// File: rtl/bo_pkg.sv
package bo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DEFER   = 2'd1,
    ST_XMIT    = 2'd2,
    ST_BACKOFF = 2'd3
  } bo_state_t;
endpackage

// File: rtl/bo_lfsr.sv
// Free-running Galois LFSR used as the random source.
module bo_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
  end

  assign state_o = state_q;

  // R5: random source must never lock up in the all-zero state
  a_r5_lfsr_alive: assert property (@(posedge clk) disable iff (rst) state_q != '0);
endmodule

// File: rtl/bo_quiet_timer.sv
// Counts consecutive idle-line cycles, saturating at the required interval.
module bo_quiet_timer #(
  parameter int QUIET_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic carrier_i,
  output logic quiet_o
);
  localparam int QW = $clog2(QUIET_CYC + 1);
  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || carrier_i)            cnt_q <= '0;
    else if (cnt_q != QW'(QUIET_CYC)) cnt_q <= cnt_q + 1'b1;
  end

  assign quiet_o = (cnt_q == QW'(QUIET_CYC));

  // R3: a busy line at the previous edge can never leave the line reported quiet
  a_r3_quiet_after_idle: assert property (@(posedge clk) disable iff (rst)
    quiet_o |-> !$past(carrier_i));
endmodule

// File: rtl/bo_slot_timer.sv
// Waits a loaded number of slots, each SLOT_CYC clock cycles long.
module bo_slot_timer #(
  parameter int SLOT_CYC = 4,
  parameter int SLOT_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] slots_i,
  output logic              expired_o
);
  localparam int SUB_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;

  logic [SLOT_W-1:0] slots_q;
  logic [SUB_W-1:0]  sub_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slots_q <= '0;
      sub_q   <= '0;
    end else if (load_i) begin
      slots_q <= slots_i;
      sub_q   <= '0;
    end else if (slots_q != '0) begin
      if (sub_q == SUB_W'(SLOT_CYC - 1)) begin
        sub_q   <= '0;
        slots_q <= slots_q - 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign expired_o = (slots_q == '0);

  // R5: without a new load the remaining slot count never grows
  a_r5_slots_shrink: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> slots_q <= $past(slots_q));
endmodule

// File: rtl/backoff_ctrl.sv
module backoff_ctrl
  import bo_pkg::*;
#(
  parameter int QUIET_CYC    = 8,
  parameter int SLOT_CYC     = 4,
  parameter int MAX_ATTEMPTS = 16,
  parameter int BACKOFF_CAP  = 10,
  parameter int LFSR_W       = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             send_req_i,
  input  logic             carrier_i,
  input  logic             collision_i,
  input  logic             tx_done_i,
  output logic             tx_en_o,
  output logic             abort_o,
  output logic             success_o,
  output logic             fail_o,
  output logic [ATT_W-1:0] attempts_o
);
  bo_state_t          state_q;
  logic [ATT_W-1:0]   attempts_q;
  logic               tx_en_q, abort_q, success_q, fail_q;
  logic [ATT_W-1:0]   next_attempt;
  logic               last_try;
  logic               quiet_ok, delay_done, load_delay;
  logic [LFSR_W-1:0]  rnd;
  logic [BACKOFF_CAP-1:0] range_mask, draw;

  bo_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .state_o(rnd));

  bo_quiet_timer #(.QUIET_CYC(QUIET_CYC)) u_quiet (
    .clk(clk), .rst(rst), .carrier_i(carrier_i), .quiet_o(quiet_ok));

  bo_slot_timer #(.SLOT_CYC(SLOT_CYC), .SLOT_W(BACKOFF_CAP)) u_slots (
    .clk(clk), .rst(rst), .load_i(load_delay), .slots_i(draw),
    .expired_o(delay_done));

  assign next_attempt = attempts_q + 1'b1;
  assign last_try     = (next_attempt == ATT_W'(MAX_ATTEMPTS));

  // Range mask holds min(n, BACKOFF_CAP) ones for the n-th collision.
  for (genvar i = 0; i < BACKOFF_CAP; i++) begin : g_mask
    assign range_mask[i] = (i < int'(next_attempt));
  end
  assign draw       = rnd[BACKOFF_CAP-1:0] & range_mask;
  assign load_delay = (state_q == ST_XMIT) && collision_i && !last_try;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      attempts_q <= '0;
      tx_en_q    <= 1'b0;
      abort_q    <= 1'b0;
      success_q  <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      abort_q   <= 1'b0;
      success_q <= 1'b0;
      fail_q    <= 1'b0;
      case (state_q)
        ST_IDLE: if (send_req_i) begin
          state_q    <= ST_DEFER;
          attempts_q <= '0;
        end
        ST_DEFER: if (quiet_ok) begin
          state_q <= ST_XMIT;
          tx_en_q <= 1'b1;
        end
        ST_XMIT: if (collision_i) begin
          tx_en_q    <= 1'b0;
          abort_q    <= 1'b1;
          attempts_q <= next_attempt;
          if (last_try) begin
            fail_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_BACKOFF;
          end
        end else if (tx_done_i) begin
          tx_en_q    <= 1'b0;
          success_q  <= 1'b1;
          attempts_q <= '0;
          state_q    <= ST_IDLE;
        end
        ST_BACKOFF: if (delay_done) state_q <= ST_DEFER;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_en_o    = tx_en_q;
  assign abort_o    = abort_q;
  assign success_o  = success_q;
  assign fail_o     = fail_q;
  assign attempts_o = attempts_q;

  // R4: abort ends a transmission that was running
  a_r4_abort_ends_tx: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> (!tx_en_o && $past(tx_en_o)));
  // R4: abort is a single-cycle pulse
  a_r4_abort_pulse: assert property (@(posedge clk) disable iff (rst)
    abort_o |=> !abort_o);
  // R6: success ends a transmission and clears the count
  a_r6_success_ends_tx: assert property (@(posedge clk) disable iff (rst)
    success_o |-> (!tx_en_o && $past(tx_en_o) && attempts_o == '0));
  // R7: success and abort never coincide
  a_r7_no_both: assert property (@(posedge clk) disable iff (rst)
    !(success_o && abort_o));
  // R8: failure only with abort at the limit
  a_r8_fail_at_limit: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> (abort_o && attempts_o == ATT_W'(MAX_ATTEMPTS)));
  // R8: count never passes the limit
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    attempts_o <= ATT_W'(MAX_ATTEMPTS));
  // R1: outputs are idle right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!tx_en_o && !abort_o && !success_o && !fail_o));
endmodule

// File: tb/backoff_ctrl_tb_top.sv
module backoff_ctrl_tb_top;
  localparam int QUIET = 5;
  localparam int SLOT  = 3;
  localparam int MAXA  = 16;
  localparam int CAP   = 10;
  localparam int AW    = $clog2(MAXA + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, carrier = 1'b0, coll = 1'b0, done = 1'b0;
  logic tx_en, abort, success, fail;
  logic [AW-1:0] attempts;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  backoff_ctrl #(.QUIET_CYC(QUIET), .SLOT_CYC(SLOT), .MAX_ATTEMPTS(MAXA),
                 .BACKOFF_CAP(CAP)) dut_i (
    .clk(clk), .rst(rst), .send_req_i(req), .carrier_i(carrier),
    .collision_i(coll), .tx_done_i(done), .tx_en_o(tx_en), .abort_o(abort),
    .success_o(success), .fail_o(fail), .attempts_o(attempts));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Counts falling edges until tx_en is seen high.
  task automatic wait_tx(output int g);
    g = 0;
    do begin
      tick();
      g++;
    end while (!tx_en && g < 5000);
  endtask

  task automatic pulse_req();
    req = 1'b1; tick(); req = 1'b0;
  endtask

  task automatic idle_check(input int n, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (tx_en) seen = 1'b1;
    end
    check(!seen, tag, int'(seen), 0);
  endtask

  initial begin
    int g, e, k;
    repeat (3) tick();
    check(!tx_en && !abort && !success && !fail && attempts == 0,
          "R1 outputs during reset", int'(tx_en), 0);
    rst = 1'b0;
    tick();
    check(!tx_en && !abort && !success && !fail && attempts == 0,
          "R1 outputs after reset", int'(attempts), 0);
    repeat (QUIET + 2) tick();

    // R2: quiet line, grant on second edge
    pulse_req();
    check(!tx_en, "R2 not yet granted", int'(tx_en), 0);
    tick();
    check(tx_en, "R2 granted two edges after request", int'(tx_en), 1);

    // R6: done without collision
    done = 1'b1; tick(); done = 1'b0;
    check(success && !tx_en && attempts == 0, "R6 success pulse", int'(success), 1);
    tick();
    check(!success, "R6 success one cycle", int'(success), 0);

    // R3: carrier restarts the quiet count
    carrier = 1'b1;
    pulse_req();
    repeat (3) tick();
    check(!tx_en, "R3 held while busy", int'(tx_en), 0);
    carrier = 1'b0; repeat (3) tick();
    carrier = 1'b1; tick();
    carrier = 1'b0;
    wait_tx(g);
    check(g == QUIET + 1, "R3 grant after quiet interval", g, QUIET + 1);

    // R7: collision and done together
    coll = 1'b1; done = 1'b1; tick(); coll = 1'b0; done = 1'b0;
    check(abort && !success, "R7 collision wins", int'(success), 0);
    check(!tx_en && attempts == 1, "R4 abort drops tx and counts", int'(attempts), 1);
    tick();
    check(!abort, "R4 abort one cycle", int'(abort), 0);
    wait_tx(g);
    g = g + 1;
    k = (g - 2) / SLOT;
    check(g >= 2 && (g - 2) % SLOT == 0 && k <= 1, "R5 first retry delay", g, 2 + SLOT);
    done = 1'b1; tick(); done = 1'b0;
    check(success && attempts == 0, "R6 success after retry clears count", int'(attempts), 0);

    // R10: request during transmission ignored
    pulse_req();
    wait_tx(g);
    pulse_req();
    done = 1'b1; tick(); done = 1'b0;
    check(success, "R10 transmission completes", int'(success), 1);
    idle_check(20, "R10 stray request ignored");

    // Full runs; run 0 ends in success after 5 collisions.
    for (int run = 0; run < 4; run++) begin
      pulse_req();
      check(attempts == 0, "R9 count cleared at acceptance", int'(attempts), 0);
      wait_tx(g);
      for (int n = 1; n <= MAXA; n++) begin
        if (run == 0 && n == 6) begin
          done = 1'b1; tick(); done = 1'b0;
          check(success && attempts == 0, "R6 success after several collisions",
                int'(attempts), 0);
          break;
        end
        coll = 1'b1; tick(); coll = 1'b0;
        check(abort && !tx_en && attempts == n, "R4 collision handling",
              int'(attempts), n);
        check(fail == (n == MAXA), "R8 failure only at limit", int'(fail), int'(n == MAXA));
        if (n == MAXA) begin
          tick();
          check(!fail && !abort, "R8 failure one cycle", int'(fail), 0);
          idle_check(40, "R8 no retry after failure");
        end else begin
          wait_tx(g);
          e = (n < CAP) ? n : CAP;
          k = (g - 2) / SLOT;
          check(g >= 2 && (g - 2) % SLOT == 0 && k <= (1 << e) - 1,
                "R5 retry delay in doubled range", g, 2 + SLOT * ((1 << e) - 1));
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule